// File: doc/BRIEF.md
# Modular-Exponentiation Accelerator Control Registers

This block is the software-visible control and status register file in front of a modular-exponentiation accelerator. A processor reaches it over a simple 32-bit bus with a byte address, a write enable, write data and combinational read data. Software programs the loader command, the staging buffer base address and byte length, and the packed bit lengths of the exponent and the modulus. It then launches the operation with one write that sets both trigger bits. The block turns that write into a one-cycle start pulse toward the exponentiation core and another toward the DMA loader. It drives the stored configuration onto dedicated output pins.

When the core reports completion with a one-cycle done pulse, the block drops its busy state and latches a completion flag in the interrupt status register. The interrupt line is the status flag gated by the interrupt mask. Software clears the flag by writing back the value it read. Afterwards it writes zero to the trigger register, which stops the engine. The memory-ownership bit of the command register decides whether the scratch memory is reachable from the CPU bus or held by the engine.

Top module: `mexp_regs`

## Requirements
- R1: After reset every register reads zero, and core_start, dma_start, irq and all configuration outputs are zero.
- R2: The command register (offset 0x048) keeps only bits [5:4] (loader mode, 2'b11 selects the exponentiation memory load) and bit 8 (1 = scratch memory owned by the CPU bus, 0 = owned by the engine). These bits drive dma_load_mode and dmem_cpu_own. All other bits read zero.
- R3: The source base (offset 0x04C) and the transfer length (offset 0x050) are full 32-bit read/write registers that drive dma_src_base and dma_len.
- R4: The key-length register (offset 0x058) holds the exponent bit length in bits [31:16], driven on exp_bits, and the modulus bit length in bits [15:0], driven on mod_bits.
- R5: Reads of any offset other than 0x000, 0x048, 0x04C, 0x050, 0x058, 0x3F8 and 0x3FC return zero. Writes to such offsets change no register.
- R6: A write to the trigger register (offset 0x000) with bits [1:0] = 2'b11 while idle raises core_start and dma_start together for exactly the one cycle after the write. It sets busy, which reads as bit 8 of the trigger register, and the trigger register then reads bits [1:0] = 2'b11.
- R7: A trigger write with a nonzero value other than 2'b11 in bits [1:0] is ignored, and so is any nonzero trigger write while busy. Such a write produces no start pulse and changes no trigger bit or busy state.
- R8: A done pulse clears busy and sets interrupt status bit 1. The trigger bits keep their value.
- R9: The interrupt mask (offset 0x3F8) keeps only bit 1. irq is high exactly while status bit 1 and mask bit 1 are both set.
- R10: The interrupt status (offset 0x3FC) is write-one-to-clear. Writing 1 to bit 1 clears it, and writing 0 leaves it unchanged.
- R11: A write of zero to the trigger register clears both trigger bits and busy.
- R12: If a done pulse and a write-one-to-clear of status bit 1 occur in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| core_done | input | 1 | One-cycle completion pulse from the core |
| core_start | output | 1 | One-cycle start pulse to the core |
| dma_start | output | 1 | One-cycle start pulse to the DMA loader |
| dma_load_mode | output | 2 | Loader mode field of the command register |
| dmem_cpu_own | output | 1 | Scratch memory owned by the CPU bus when high |
| dma_src_base | output | 32 | Staging buffer base address |
| dma_len | output | 32 | Staging buffer length in bytes |
| exp_bits | output | 16 | Exponent length in bits |
| mod_bits | output | 16 | Modulus length in bits |
| irq | output | 1 | Completion interrupt |

## Verification
The properties assume that core_done arrives as a single-cycle pulse and that the bus holds a write for exactly one cycle with a stable address. The start-pulse and busy properties look back only one cycle to the triggering write. The bench drives every bus access for one cycle from the falling clock edge. Its behavioural core model answers each start pulse with a single done pulse after a fixed delay. The same-cycle collision between done and a status clear is produced by hand, with the model switched off, so that no second done can arrive unseen.

// File: rtl/mexp_regs_pkg.sv
package mexp_regs_pkg;

  localparam int unsigned REG_W     = 32;
  localparam int unsigned OFS_W     = 12;
  localparam int unsigned TRIG_W    = 2;
  localparam int unsigned BUSY_POS  = 8;
  localparam int unsigned MODE_LO   = 4;
  localparam int unsigned MODE_W    = 2;
  localparam int unsigned OWN_POS   = 8;
  localparam int unsigned HALF_W    = REG_W / 2;
  localparam int unsigned DONE_POS  = 1;
  localparam int unsigned NUM_CFG   = 4;

  localparam logic [OFS_W-1:0] OFS_TRIG   = 12'h000;
  localparam logic [OFS_W-1:0] OFS_CMD    = 12'h048;
  localparam logic [OFS_W-1:0] OFS_BASE   = 12'h04C;
  localparam logic [OFS_W-1:0] OFS_LEN    = 12'h050;
  localparam logic [OFS_W-1:0] OFS_KEYLEN = 12'h058;
  localparam logic [OFS_W-1:0] OFS_MASK   = 12'h3F8;
  localparam logic [OFS_W-1:0] OFS_STAT   = 12'h3FC;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_TRIG,
    SEL_CMD,
    SEL_BASE,
    SEL_LEN,
    SEL_KEYLEN,
    SEL_MASK,
    SEL_STAT
  } reg_sel_e;

  localparam logic [REG_W-1:0] CMD_WMASK =
    (REG_W'((1 << MODE_W) - 1) << MODE_LO) | (REG_W'(1) << OWN_POS);

  function automatic reg_sel_e cfg_sel(input int unsigned idx);
    case (idx)
      0:       cfg_sel = SEL_CMD;
      1:       cfg_sel = SEL_BASE;
      2:       cfg_sel = SEL_LEN;
      default: cfg_sel = SEL_KEYLEN;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] cfg_wmask(input int unsigned idx);
    cfg_wmask = (idx == 0) ? CMD_WMASK : '1;
  endfunction

endpackage

// File: rtl/mexp_reg_decode.sv
module mexp_reg_decode
  import mexp_regs_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);

  always_comb begin
    sel = SEL_NONE;
    if      (addr == ADDR_W'(OFS_TRIG))   sel = SEL_TRIG;
    else if (addr == ADDR_W'(OFS_CMD))    sel = SEL_CMD;
    else if (addr == ADDR_W'(OFS_BASE))   sel = SEL_BASE;
    else if (addr == ADDR_W'(OFS_LEN))    sel = SEL_LEN;
    else if (addr == ADDR_W'(OFS_KEYLEN)) sel = SEL_KEYLEN;
    else if (addr == ADDR_W'(OFS_MASK))   sel = SEL_MASK;
    else if (addr == ADDR_W'(OFS_STAT))   sel = SEL_STAT;
  end

endmodule

// File: rtl/mexp_cfg_word.sv
module mexp_cfg_word
  import mexp_regs_pkg::*;
#(
  parameter logic [REG_W-1:0] WMASK = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] q
);

  logic [REG_W-1:0] q_d;
  logic [REG_W-1:0] q_r;

  always_comb begin
    q_d = q_r;
    if (wr) q_d = wdata & WMASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else if (wr) q_r <= q_d;
  end

  assign q = q_r;

endmodule

// File: rtl/mexp_trig_ctrl.sv
module mexp_trig_ctrl
  import mexp_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [TRIG_W-1:0] wr_bits,
  input  logic              done,
  output logic [TRIG_W-1:0] trig_bits,
  output logic              busy,
  output logic [TRIG_W-1:0] go_pulse
);

  logic [TRIG_W-1:0] bits_q, bits_d;
  logic              busy_q, busy_d;
  logic [TRIG_W-1:0] go_q, go_d;
  logic              accept;
  logic              stop;
  logic              upd;

  assign accept = wr_hit && !busy_q && (wr_bits == {TRIG_W{1'b1}});
  assign stop   = wr_hit && (wr_bits == '0);

  always_comb begin
    bits_d = bits_q;
    busy_d = busy_q;
    if (done) busy_d = 1'b0;
    if (stop) begin
      bits_d = '0;
      busy_d = 1'b0;
    end
    if (accept) begin
      bits_d = {TRIG_W{1'b1}};
      busy_d = 1'b1;
    end
  end

  assign upd = done || stop || accept;

  always_comb begin
    go_d = '0;
    if (accept) go_d = wr_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q <= '0;
      busy_q <= 1'b0;
    end else if (upd) begin
      bits_q <= bits_d;
      busy_q <= busy_d;
    end
  end

  genvar g;
  generate
    for (g = 0; g < TRIG_W; g++) begin : g_go
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) go_q[g] <= 1'b0;
        else        go_q[g] <= go_d[g];
      end
    end
  endgenerate

  assign trig_bits = bits_q;
  assign busy      = busy_q;
  assign go_pulse  = go_q;

endmodule

// File: rtl/mexp_irq_ctrl.sv
module mexp_irq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic stat_wr,
  input  logic mask_wr,
  input  logic wr_bit,
  input  logic done,
  output logic sts,
  output logic msk,
  output logic irq
);

  logic sts_q, sts_d;
  logic msk_q, msk_d;

  always_comb begin
    sts_d = sts_q;
    if (stat_wr && wr_bit) sts_d = 1'b0;
    if (done)              sts_d = 1'b1;
  end

  always_comb begin
    msk_d = msk_q;
    if (mask_wr) msk_d = wr_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= 1'b0;
      msk_q <= 1'b0;
    end else begin
      if (stat_wr || done) sts_q <= sts_d;
      if (mask_wr)         msk_q <= msk_d;
    end
  end

  assign sts = sts_q;
  assign msk = msk_q;
  assign irq = sts_q & msk_q;

endmodule

// File: rtl/mexp_regs.sv
module mexp_regs
  import mexp_regs_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              core_done,
  output logic              core_start,
  output logic              dma_start,
  output logic [1:0]        dma_load_mode,
  output logic              dmem_cpu_own,
  output logic [31:0]       dma_src_base,
  output logic [31:0]       dma_len,
  output logic [15:0]       exp_bits,
  output logic [15:0]       mod_bits,
  output logic              irq
);

  reg_sel_e          sel;
  logic [REG_W-1:0]  cfg_q [NUM_CFG];
  logic [TRIG_W-1:0] trig_bits;
  logic              trig_busy;
  logic [TRIG_W-1:0] go_pulse;
  logic              int_sts;
  logic              int_msk;

  mexp_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .sel  (sel)
  );

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CFG; gi++) begin : g_cfg
      mexp_cfg_word #(.WMASK(cfg_wmask(gi))) u_word (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (bus_we && (sel == cfg_sel(gi))),
        .wdata (bus_wdata),
        .q     (cfg_q[gi])
      );
    end
  endgenerate

  mexp_trig_ctrl u_trig (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_hit    (bus_we && (sel == SEL_TRIG)),
    .wr_bits   (bus_wdata[TRIG_W-1:0]),
    .done      (core_done),
    .trig_bits (trig_bits),
    .busy      (trig_busy),
    .go_pulse  (go_pulse)
  );

  mexp_irq_ctrl u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .stat_wr (bus_we && (sel == SEL_STAT)),
    .mask_wr (bus_we && (sel == SEL_MASK)),
    .wr_bit  (bus_wdata[DONE_POS]),
    .done    (core_done),
    .sts     (int_sts),
    .msk     (int_msk),
    .irq     (irq)
  );

  always_comb begin
    bus_rdata = '0;
    case (sel)
      SEL_TRIG:   bus_rdata = REG_W'(trig_bits) | (REG_W'(trig_busy) << BUSY_POS);
      SEL_CMD:    bus_rdata = cfg_q[0];
      SEL_BASE:   bus_rdata = cfg_q[1];
      SEL_LEN:    bus_rdata = cfg_q[2];
      SEL_KEYLEN: bus_rdata = cfg_q[3];
      SEL_MASK:   bus_rdata = REG_W'(int_msk) << DONE_POS;
      SEL_STAT:   bus_rdata = REG_W'(int_sts) << DONE_POS;
      default:    bus_rdata = '0;
    endcase
  end

  assign core_start    = go_pulse[0];
  assign dma_start     = go_pulse[1];
  assign dma_load_mode = cfg_q[0][MODE_LO +: MODE_W];
  assign dmem_cpu_own  = cfg_q[0][OWN_POS];
  assign dma_src_base  = cfg_q[1];
  assign dma_len       = cfg_q[2];
  assign exp_bits      = cfg_q[3][REG_W-1:HALF_W];
  assign mod_bits      = cfg_q[3][HALF_W-1:0];

endmodule

// File: rtl/mexp_regs_chk.sv
module mexp_regs_chk
  import mexp_regs_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [31:0]       bus_wdata,
  input logic              core_done,
  input logic              core_start,
  input logic              dma_start,
  input logic              irq,
  input logic              busy,
  input logic              sts_done,
  input logic              msk_done
);

  logic trig_wr;
  logic stat_wr;
  logic mask_wr;

  assign trig_wr = bus_we && (bus_addr == ADDR_W'(OFS_TRIG));
  assign stat_wr = bus_we && (bus_addr == ADDR_W'(OFS_STAT));
  assign mask_wr = bus_we && (bus_addr == ADDR_W'(OFS_MASK));

  AST_START_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |-> $past(trig_wr && (bus_wdata[1:0] == 2'b11))); // R6

  AST_DMA_WITH_CORE: assert property (@(posedge clk) disable iff (!rst_n)
    dma_start |-> core_start); // R6

  AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |-> !$past(busy)); // R7

  AST_DONE_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (core_done && busy) |=> !busy); // R8

  AST_DONE_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    core_done |=> sts_done); // R12

  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(core_done) || $past(mask_wr))); // R9

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && bus_wdata[1] && !core_done) |=> !sts_done); // R10

  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_wr && (bus_wdata[1:0] == 2'b00)) |=> !busy); // R11

endmodule

bind mexp_regs mexp_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_addr   (bus_addr),
  .bus_we     (bus_we),
  .bus_wdata  (bus_wdata),
  .core_done  (core_done),
  .core_start (core_start),
  .dma_start  (dma_start),
  .irq        (irq),
  .busy       (trig_busy),
  .sts_done   (int_sts),
  .msk_done   (int_msk)
);

// File: tb/sim_mexp_regs.sv
`timescale 1ns/1ps
module sim_mexp_regs;

  localparam int unsigned AW = 12;

  logic          clk;
  logic          rst_n;
  logic [AW-1:0] bus_addr;
  logic          bus_we;
  logic [31:0]   bus_wdata;
  logic [31:0]   bus_rdata;
  logic          core_done;
  logic          core_start;
  logic          dma_start;
  logic [1:0]    dma_load_mode;
  logic          dmem_cpu_own;
  logic [31:0]   dma_src_base;
  logic [31:0]   dma_len;
  logic [15:0]   exp_bits;
  logic [15:0]   mod_bits;
  logic          irq;

  logic          model_en;
  int            model_dly;
  int            model_cnt;
  logic          model_done;
  logic          man_done;

  int n_chk;
  int n_fail;
  logic finished;

  assign core_done = model_done | man_done;

  mexp_regs #(.ADDR_W(AW)) u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_addr      (bus_addr),
    .bus_we        (bus_we),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .core_done     (core_done),
    .core_start    (core_start),
    .dma_start     (dma_start),
    .dma_load_mode (dma_load_mode),
    .dmem_cpu_own  (dmem_cpu_own),
    .dma_src_base  (dma_src_base),
    .dma_len       (dma_len),
    .exp_bits      (exp_bits),
    .mod_bits      (mod_bits),
    .irq           (irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // behavioural core: one done pulse a fixed delay after each start
  always @(negedge clk) begin
    model_done <= 1'b0;
    if (!rst_n) begin
      model_cnt <= 0;
    end else if (model_en) begin
      if (core_start) begin
        model_cnt <= model_dly;
      end else if (model_cnt != 0) begin
        model_cnt <= model_cnt - 1;
        if (model_cnt == 1) model_done <= 1'b1;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    @(negedge clk);
    bus_we    = 1'b0;
    bus_wdata = '0;
  endtask

  task automatic bus_rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    bus_rd(12'h000, v); check("R1 trigger", v, 0);
    bus_rd(12'h048, v); check("R1 command", v, 0);
    bus_rd(12'h058, v); check("R1 keylen", v, 0);
    bus_rd(12'h3FC, v); check("R1 status", v, 0);
    check("R1 outputs", {core_start, dma_start, irq, dmem_cpu_own, dma_load_mode}, 0);
    check("R1 cfg outs", dma_src_base | dma_len | {exp_bits, mod_bits}, 0);
  endtask

  task automatic t_config;
    logic [31:0] v;
    bus_wr(12'h048, 32'hFFFF_FFFF);
    bus_rd(12'h048, v); check("R2 cmd mask", v, 32'h0000_0130);
    check("R2 mode out", {30'd0, dma_load_mode}, 3);
    check("R2 own out", {31'd0, dmem_cpu_own}, 1);
    bus_wr(12'h048, 32'h0000_0030);
    check("R2 engine owns", {31'd0, dmem_cpu_own}, 0);
    bus_wr(12'h04C, 32'h8765_4320);
    bus_wr(12'h050, 32'h0000_1800);
    bus_rd(12'h04C, v); check("R3 base rd", v, 32'h8765_4320);
    bus_rd(12'h050, v); check("R3 len rd", v, 32'h0000_1800);
    check("R3 base out", dma_src_base, 32'h8765_4320);
    check("R3 len out", dma_len, 32'h0000_1800);
    bus_wr(12'h058, 32'h0011_0800);
    check("R4 exp bits", {16'd0, exp_bits}, 17);
    check("R4 mod bits", {16'd0, mod_bits}, 2048);
  endtask

  task automatic t_undefined;
    logic [31:0] v;
    bus_wr(12'h054, 32'hDEAD_BEEF);
    bus_wr(12'h04D, 32'h1111_1111);
    bus_rd(12'h054, v); check("R5 undef read", v, 0);
    bus_rd(12'h04C, v); check("R5 base kept", v, 32'h8765_4320);
    bus_rd(12'h050, v); check("R5 len kept", v, 32'h0000_1800);
    bus_rd(12'h058, v); check("R5 keylen kept", v, 32'h0011_0800);
  endtask

  task automatic t_start_and_done;
    logic [31:0] v;
    model_dly = 20;
    model_en  = 1'b1;
    bus_wr(12'h000, 32'h3);
    check("R6 start pulses", {30'd0, core_start, dma_start}, 3);
    @(negedge clk);
    check("R6 single pulse", {30'd0, core_start, dma_start}, 0);
    bus_rd(12'h000, v); check("R6 busy read", v, 32'h0000_0103);
    bus_wr(12'h000, 32'h3);
    check("R7 busy retrigger", {30'd0, core_start, dma_start}, 0);
    bus_rd(12'h000, v); check("R7 still busy", v, 32'h0000_0103);
    repeat (30) @(negedge clk);
    bus_rd(12'h000, v); check("R8 busy cleared", v, 32'h0000_0003);
    bus_rd(12'h3FC, v); check("R8 status set", v, 32'h2);
    check("R9 masked irq", {31'd0, irq}, 0);
    bus_wr(12'h3F8, 32'hFFFF_FFFF);
    bus_rd(12'h3F8, v); check("R9 mask bits", v, 32'h2);
    check("R9 irq on", {31'd0, irq}, 1);
    bus_wr(12'h3FC, 32'h0);
    bus_rd(12'h3FC, v); check("R10 zero keeps", v, 32'h2);
    bus_wr(12'h3FC, 32'h2);
    bus_rd(12'h3FC, v); check("R10 w1c", v, 0);
    check("R9 irq off", {31'd0, irq}, 0);
    bus_wr(12'h000, 32'h0);
    bus_rd(12'h000, v); check("R11 stop idle", v, 0);
  endtask

  task automatic t_stop_busy;
    logic [31:0] v;
    model_dly = 40;
    model_en  = 1'b1;
    bus_wr(12'h000, 32'h1);
    check("R7 partial no start", {31'd0, core_start}, 0);
    bus_rd(12'h000, v); check("R7 partial ignored", v, 0);
    bus_wr(12'h000, 32'h3);
    check("R6 restart", {31'd0, core_start}, 1);
    bus_wr(12'h000, 32'h0);
    bus_rd(12'h000, v); check("R11 stop busy", v, 0);
    repeat (50) @(negedge clk);
    bus_wr(12'h3FC, 32'h2);
    bus_rd(12'h3FC, v); check("R10 cleared", v, 0);
  endtask

  task automatic t_collision;
    logic [31:0] v;
    model_en = 1'b0;
    @(negedge clk);
    bus_addr  = 12'h3FC;
    bus_wdata = 32'h2;
    bus_we    = 1'b1;
    man_done  = 1'b1;
    @(negedge clk);
    bus_we    = 1'b0;
    man_done  = 1'b0;
    bus_rd(12'h3FC, v); check("R12 set wins", v, 32'h2);
    check("R12 irq", {31'd0, irq}, 1);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; finished = 1'b0;
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    man_done = 1'b0; model_en = 1'b0; model_dly = 20;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_config();
    t_undefined();
    t_start_and_done();
    t_stop_busy();
    t_collision();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule